// File: doc/BRIEF.md
# Disk Bus Controller Condition and Interrupt Logic

This block keeps the condition register of a disk bus controller and decides when the controller asks the processor for an interrupt. Software writes an 18-bit condition word. That word selects an interrupt priority channel, turns the attention interrupt on or off, and carries strobes that clear groups of flags. Reading returns the current condition word. Up to eight drives send attention set and clear pulses, which build an attention summary. The transfer logic sends event pulses for command done, register access error and drive exception.

The interrupt request is a 7-bit one-hot level taken from the 3-bit channel field. There are three independent sources of interrupt plus a one-shot drive exception source, and each has its own rule for when it may interrupt. A controller-clear strobe wipes the flags and sends a one-cycle reset pulse to every drive.

Top module: `mbc_irq_status`

## Requirements
- R1: After reset, the condition word, the attention summary, the interrupt level and the drive reset vector are all zero.
- R2: Every condition write loads bits [2:0] as the interrupt channel. A channel c from 1 to 7 requests level bit (7 − c) of `irq_level`. Channel 0 requests nothing.
- R3: Every condition write sets the attention interrupt enable from its bit 4, whether that bit is 1 or 0.
- R4: In a condition write, each of these bits clears its flag only when it is 1: bit 3 clears command done, bit 7 clears register access error, bit 6 clears the transfer error flags (drive exception), and bit 5 clears both command-file-full flags. A 0 in any of these bits leaves its flag unchanged.
- R5: An attention set pulse sets that drive's bit in `att_summary` and sets bus attention. An attention clear pulse removes the drive's bit. Bus attention drops only when the summary becomes zero.
- R6: Command done requests an interrupt whatever the enables are.
- R7: Bus attention requests an interrupt only while the attention enable is 1.
- R8: Register access error requests an interrupt only while `prep_irq_dis` is 0.
- R9: A drive exception event requests an interrupt only when the exception flag goes from 0 to 1. That request is withdrawn by the next condition write, and a further event does not raise it again while the flag is still set.
- R10: Condition write bit 8 zeroes every flag and withdraws any request. In the next cycle it drives all bits of `drv_reset` high for exactly one cycle. The channel and enable carried by the same write are still loaded.
- R11: `irq_level` is registered. It follows the condition state one cycle after that state changes, so a change of channel moves the request to the new level or withdraws it.
- R12: An event pulse that arrives in the same cycle as a write that clears its flag wins, and the flag stays set.
- R13: The read word is laid out as follows: [2:0] channel, 3 command done, 4 attention enable, 5 bus attention, 6 register access error, 7 drive exception, 8 primary command file full, 9 secondary command file full. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_wr | input | 1 | Condition write strobe |
| cond_wdata | input | 18 | Condition write word |
| cond_rdata | output | 18 | Current condition word |
| prep_irq_dis | input | 1 | Register-error interrupt disable from the preparation register |
| att_set | input | 8 | Per-drive attention assert pulses |
| att_clr | input | 8 | Per-drive attention release pulses |
| ev_cmd_done | input | 1 | Command done event |
| ev_reg_err | input | 1 | Register access error event |
| ev_drv_exc | input | 1 | Drive exception event |
| cf_full_set | input | 2 | Set pulses for primary (bit 0) and secondary (bit 1) command-file-full |
| att_summary | output | 8 | Per-drive attention summary |
| irq_level | output | 7 | One-hot interrupt level request |
| drv_reset | output | 8 | One-cycle reset pulse to each drive |

## Verification
The assertions check on every cycle that the request is one-hot or zero and that a request only follows a qualifying condition in the previous cycle. They also check that command done with a nonzero channel always produces a request, that attention pulses reach the summary, that the enable follows each write, and that controller clear pulses every drive reset. The one-shot behaviour of the drive exception, the masking by `prep_irq_dis` and the enable, the precedence of events over clears, and the exact level chosen for each channel depend on ordered sequences. Only the bench scenarios, checked against a cycle model, can show those.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  // condition write bit positions (channel field occupies the bits below 3)
  localparam int WB_CLR_DONE = 3;
  localparam int WB_ATT_EN   = 4;
  localparam int WB_CLR_CF   = 5;
  localparam int WB_CLR_XERR = 6;
  localparam int WB_CLR_RAE  = 7;
  localparam int WB_CTRL_CLR = 8;

  // condition read bit positions
  localparam int RB_DONE = 3;
  localparam int RB_AEN  = 4;
  localparam int RB_MBA  = 5;
  localparam int RB_RAE  = 6;
  localparam int RB_EXC  = 7;
  localparam int RB_PCF  = 8;
  localparam int RB_SCF  = 9;

  typedef struct packed {
    logic scf;
    logic pcf;
    logic exc;
    logic rae;
    logic done;
  } flags_t;

  // interrupt qualification: each source with its own enable rule
  function automatic logic wants_irq(flags_t f, logic mba, logic aen,
                                     logic pend, logic err_dis);
    return f.done | (mba & aen) | (f.rae & ~err_dis) | pend;
  endfunction
endpackage

// File: rtl/mbc_attn_summary.sv
module mbc_attn_summary #(
  parameter int NDRV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDRV-1:0] att_set,
  input  logic [NDRV-1:0] att_clr,
  input  logic            ctrl_clr,
  output logic [NDRV-1:0] summary,
  output logic            mba
);
  logic [NDRV-1:0] sum_n;
  logic            mba_n;

  always_comb begin
    sum_n = (summary & ~att_clr) | att_set;
    // bus attention: set by any assert, held while any drive still flagged
    mba_n = (|att_set) | (mba & ~ctrl_clr & (|sum_n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      summary <= '0;
      mba     <= 1'b0;
    end else begin
      summary <= sum_n;
      mba     <= mba_n;
    end
  end
endmodule

// File: rtl/mbc_cond_reg.sv
module mbc_cond_reg
  import mbc_pkg::*;
#(
  parameter int CHW = 3,
  parameter int WW  = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [WW-1:0]  wdata,
  input  logic           ev_done,
  input  logic           ev_rae,
  input  logic           ev_exc,
  input  logic [1:0]     cf_set,
  output flags_t         flags,
  output logic [CHW-1:0] chan,
  output logic           aen,
  output logic           pend,
  output logic           ctrl_clr
);
  flags_t n;
  logic   clr_done, clr_rae, clr_xerr, clr_cf;

  always_comb begin
    ctrl_clr = wr & wdata[WB_CTRL_CLR];
    clr_done = (wr & wdata[WB_CLR_DONE]) | ctrl_clr;
    clr_rae  = (wr & wdata[WB_CLR_RAE])  | ctrl_clr;
    clr_xerr = (wr & wdata[WB_CLR_XERR]) | ctrl_clr;
    clr_cf   = (wr & wdata[WB_CLR_CF])   | ctrl_clr;
    // events are applied after clears, so a same-cycle event survives
    n.done = ev_done   | (flags.done & ~clr_done);
    n.rae  = ev_rae    | (flags.rae  & ~clr_rae);
    n.exc  = ev_exc    | (flags.exc  & ~clr_xerr);
    n.pcf  = cf_set[0] | (flags.pcf  & ~clr_cf);
    n.scf  = cf_set[1] | (flags.scf  & ~clr_cf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      chan  <= '0;
      aen   <= 1'b0;
      pend  <= 1'b0;
    end else begin
      flags <= n;
      if (wr) begin
        chan <= wdata[CHW-1:0];
        aen  <= wdata[WB_ATT_EN];
      end
      // exception request only on the flag's rising transition
      pend <= (ev_exc & ~flags.exc) | (pend & ~wr);
    end
  end
endmodule

// File: rtl/mbc_irq_gen.sv
module mbc_irq_gen #(
  parameter int CHW = 3,
  localparam int LVLW = (1 << CHW) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            qual,
  input  logic [CHW-1:0]  chan,
  output logic [LVLW-1:0] irq_level
);
  logic [LVLW-1:0] lvl_n;

  // level bit k belongs to channel LVLW-k; channel 0 owns no bit
  for (genvar k = 0; k < LVLW; k++) begin : g_lvl
    assign lvl_n[k] = qual && (chan == CHW'(LVLW - k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_level <= '0;
    else        irq_level <= lvl_n;
  end
endmodule

// File: rtl/mbc_irq_status.sv
module mbc_irq_status
  import mbc_pkg::*;
#(
  parameter int NDRV = 8,
  parameter int CHW  = 3,
  parameter int WW   = 18,
  localparam int LVLW = (1 << CHW) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cond_wr,
  input  logic [WW-1:0]   cond_wdata,
  output logic [WW-1:0]   cond_rdata,
  input  logic            prep_irq_dis,
  input  logic [NDRV-1:0] att_set,
  input  logic [NDRV-1:0] att_clr,
  input  logic            ev_cmd_done,
  input  logic            ev_reg_err,
  input  logic            ev_drv_exc,
  input  logic [1:0]      cf_full_set,
  output logic [NDRV-1:0] att_summary,
  output logic [LVLW-1:0] irq_level,
  output logic [NDRV-1:0] drv_reset
);
  flags_t         flags;
  logic [CHW-1:0] chan;
  logic           aen, pend, mba, ctrl_clr_w, qual_w;
  wire            unused_ok = ^cond_wdata[WW-1:WB_CTRL_CLR+1];

  mbc_cond_reg #(.CHW(CHW), .WW(WW)) u_cond (
    .clk(clk), .rst_n(rst_n), .wr(cond_wr), .wdata(cond_wdata),
    .ev_done(ev_cmd_done), .ev_rae(ev_reg_err), .ev_exc(ev_drv_exc),
    .cf_set(cf_full_set), .flags(flags), .chan(chan), .aen(aen),
    .pend(pend), .ctrl_clr(ctrl_clr_w)
  );

  mbc_attn_summary #(.NDRV(NDRV)) u_attn (
    .clk(clk), .rst_n(rst_n), .att_set(att_set), .att_clr(att_clr),
    .ctrl_clr(ctrl_clr_w), .summary(att_summary), .mba(mba)
  );

  assign qual_w = wants_irq(flags, mba, aen, pend, prep_irq_dis);

  mbc_irq_gen #(.CHW(CHW)) u_irq (
    .clk(clk), .rst_n(rst_n), .qual(qual_w), .chan(chan),
    .irq_level(irq_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_reset <= '0;
    else        drv_reset <= {NDRV{ctrl_clr_w}};
  end

  always_comb begin
    cond_rdata          = '0;
    cond_rdata[CHW-1:0] = chan;
    cond_rdata[RB_DONE] = flags.done;
    cond_rdata[RB_AEN]  = aen;
    cond_rdata[RB_MBA]  = mba;
    cond_rdata[RB_RAE]  = flags.rae;
    cond_rdata[RB_EXC]  = flags.exc;
    cond_rdata[RB_PCF]  = flags.pcf;
    cond_rdata[RB_SCF]  = flags.scf;
  end
endmodule

// File: rtl/mbc_irq_status_chk.sv
module mbc_irq_status_chk #(
  parameter int NDRV = 8,
  parameter int CHW  = 3,
  localparam int LVLW = (1 << CHW) - 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cond_wr,
  input logic            wr_aen,
  input logic            wr_ctrl_clr,
  input logic            rd_done,
  input logic            rd_aen,
  input logic [CHW-1:0]  rd_chan,
  input logic [NDRV-1:0] att_set,
  input logic [NDRV-1:0] att_summary,
  input logic [LVLW-1:0] irq_level,
  input logic [NDRV-1:0] drv_reset,
  input logic            qual_w
);
  // R2
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_level));

  // R11
  irq_follows_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> $past(qual_w));

  // R6
  done_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_chan != '0) |=> (irq_level != '0));

  // R3
  aen_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_wr |=> (rd_aen == $past(wr_aen)));

  // R5
  attn_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (att_set != '0) |=> ((att_summary & $past(att_set)) == $past(att_set)));

  // R10
  drv_reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_wr && wr_ctrl_clr) |=> (drv_reset == '1));
endmodule

bind mbc_irq_status mbc_irq_status_chk #(.NDRV(NDRV), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_wr(cond_wr),
  .wr_aen(cond_wdata[4]), .wr_ctrl_clr(cond_wdata[8]),
  .rd_done(cond_rdata[3]), .rd_aen(cond_rdata[4]),
  .rd_chan(cond_rdata[CHW-1:0]), .att_set(att_set),
  .att_summary(att_summary), .irq_level(irq_level),
  .drv_reset(drv_reset), .qual_w(qual_w)
);

// File: tb/tb_mbc_irq_status.sv
module tb_mbc_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cond_wr = 0;
  logic [17:0] cond_wdata = '0;
  logic [17:0] cond_rdata;
  logic        prep_irq_dis = 0;
  logic [7:0]  att_set = '0, att_clr = '0;
  logic        ev_cmd_done = 0, ev_reg_err = 0, ev_drv_exc = 0;
  logic [1:0]  cf_full_set = '0;
  logic [7:0]  att_summary, drv_reset;
  logic [6:0]  irq_level;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // bench model of the condition state
  logic [2:0] m_chan = 0;
  logic m_aen = 0, m_done = 0, m_rae = 0, m_exc = 0, m_pcf = 0, m_scf = 0;
  logic m_mba = 0, m_pend = 0;
  logic [7:0] m_sum = 0;

  always #2.5 clk = ~clk;

  mbc_irq_status dut (.*);

  function automatic logic [6:0] lvl(int ch);
    logic [6:0] r = '0;
    for (int i = 0; i < 7; i++) if (ch != 0 && i == 7 - ch) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [17:0] packw();
    logic [17:0] r = '0;
    r[2:0] = m_chan; r[3] = m_done; r[4] = m_aen; r[5] = m_mba;
    r[6] = m_rae; r[7] = m_exc; r[8] = m_pcf; r[9] = m_scf;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic wr, logic [17:0] d, logic [7:0] as, logic [7:0] ac,
                     logic dn, logic re, logic ex, logic [1:0] cf);
    logic q, ctl;
    logic [6:0] e_irq;
    logic [7:0] n_sum;
    logic n_exc, n_pend, n_mba;
    cond_wr = wr; cond_wdata = d; att_set = as; att_clr = ac;
    ev_cmd_done = dn; ev_reg_err = re; ev_drv_exc = ex; cf_full_set = cf;
    q = m_done | (m_mba & m_aen) | (m_rae & ~prep_irq_dis) | m_pend;
    e_irq = q ? lvl(int'(m_chan)) : 7'd0;
    ctl = wr & d[8];
    n_sum  = (m_sum & ~ac) | as;
    n_mba  = (as != 0) ? 1'b1 : ((ctl || n_sum == 0) ? 1'b0 : m_mba);
    n_exc  = ex | (m_exc & ~((wr & d[6]) | ctl));
    n_pend = (ex & ~m_exc) ? 1'b1 : (wr ? 1'b0 : m_pend);
    m_done = dn | (m_done & ~((wr & d[3]) | ctl));
    m_rae  = re | (m_rae & ~((wr & d[7]) | ctl));
    m_pcf  = cf[0] | (m_pcf & ~((wr & d[5]) | ctl));
    m_scf  = cf[1] | (m_scf & ~((wr & d[5]) | ctl));
    m_exc = n_exc; m_pend = n_pend; m_sum = n_sum; m_mba = n_mba;
    if (wr) begin m_chan = d[2:0]; m_aen = d[4]; end
    @(posedge clk); @(negedge clk);
    chk("R13 cond word", 32'(cond_rdata), 32'(packw()));
    chk("R5 summary", 32'(att_summary), 32'(m_sum));
    chk("R11 irq", 32'(irq_level), 32'(e_irq));
    chk("R10 drv_reset", 32'(drv_reset), ctl ? 32'hFF : 32'h0);
  endtask

  task automatic idle();
    cyc(0, 18'h0, 8'h0, 8'h0, 0, 0, 0, 2'b00);
  endtask

  task automatic wrc(logic [17:0] d);
    cyc(1, d, 8'h0, 8'h0, 0, 0, 0, 2'b00);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 cond", 32'(cond_rdata), 0);
    chk("R1 summary", 32'(att_summary), 0);
    chk("R1 irq", 32'(irq_level), 0);
    chk("R1 drv_reset", 32'(drv_reset), 0);
    rst_n = 1'b1;
    idle();

    // R2: level for every channel with command done set
    cyc(0, 0, 0, 0, 1, 0, 0, 2'b00);
    for (int ch = 0; ch < 8; ch++) begin
      wrc(18'(ch)); idle();
      chk("R2 level", 32'(irq_level), 32'(lvl(ch)));
    end
    wrc(18'h08);
    // R6 command done alone
    wrc(18'h01); cyc(0, 0, 0, 0, 1, 0, 0, 2'b00); idle();
    chk("R6 done irq", 32'(irq_level), 32'h40);
    wrc(18'h09); idle();
    chk("R4 done cleared", 32'(cond_rdata[3]), 0);
    chk("R6 no irq after clear", 32'(irq_level), 0);

    // R7 attention with enable
    wrc(18'h13); cyc(0, 0, 8'h04, 0, 0, 0, 0, 2'b00); idle();
    chk("R7 attn irq", 32'(irq_level), 32'h10);
    wrc(18'h03); idle();
    chk("R3 enable cleared", 32'(cond_rdata[4]), 0);
    chk("R7 attn masked", 32'(irq_level), 0);
    cyc(0, 0, 8'h03, 0, 0, 0, 0, 2'b00);
    cyc(0, 0, 0, 8'h05, 0, 0, 0, 2'b00);
    chk("R5 mba holds", 32'(cond_rdata[5]), 1);
    cyc(0, 0, 0, 8'h02, 0, 0, 0, 2'b00);
    chk("R5 mba drops", 32'(cond_rdata[5]), 0);
    chk("R5 summary empty", 32'(att_summary), 0);

    // R8 register error gated by preparation disable
    wrc(18'h05); cyc(0, 0, 0, 0, 0, 1, 0, 2'b00); idle();
    chk("R8 rae irq", 32'(irq_level), 32'h04);
    prep_irq_dis = 1; idle();
    chk("R8 rae disabled", 32'(irq_level), 0);
    prep_irq_dis = 0;
    cyc(1, 18'h85, 0, 0, 0, 1, 0, 2'b00);
    chk("R12 event beats clear", 32'(cond_rdata[6]), 1);
    wrc(18'h85);
    chk("R4 rae cleared", 32'(cond_rdata[6]), 0);

    // R9 drive exception one-shot
    wrc(18'h02); cyc(0, 0, 0, 0, 0, 0, 1, 2'b00); idle();
    chk("R9 exc irq", 32'(irq_level), 32'h20);
    wrc(18'h02); idle();
    chk("R9 withdrawn by write", 32'(irq_level), 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'b00); idle(); idle();
    chk("R9 no retrigger", 32'(irq_level), 0);
    wrc(18'h42);
    chk("R4 xerr cleared", 32'(cond_rdata[7]), 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 2'b00); idle();
    chk("R9 retrigger after clear", 32'(irq_level), 32'h20);
    wrc(18'h42);

    // R4 command-file flags
    cyc(0, 0, 0, 0, 0, 0, 0, 2'b11);
    chk("R4 cf set", 32'(cond_rdata[9:8]), 3);
    wrc(18'h02);
    chk("R4 cf kept", 32'(cond_rdata[9:8]), 3);
    wrc(18'h22);
    chk("R4 cf cleared", 32'(cond_rdata[9:8]), 0);

    // R10 controller clear
    cyc(0, 0, 0, 0, 1, 0, 0, 2'b00);
    cyc(0, 0, 8'h81, 0, 0, 0, 0, 2'b00);
    wrc(18'h107);
    chk("R10 pulse", 32'(drv_reset), 32'hFF);
    chk("R10 flags zero", 32'(cond_rdata), 32'h007);
    chk("R10 summary kept", 32'(att_summary), 32'h81);
    idle();
    chk("R10 pulse ends", 32'(drv_reset), 0);
    chk("R10 irq withdrawn", 32'(irq_level), 0);
    cyc(0, 0, 0, 8'h81, 0, 0, 0, 2'b00);

    // random mix checked against the model
    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [17:0] d;
      w = ($urandom % 4) == 0;
      d = 18'($urandom);
      if (($urandom % 16) != 0) d[8] = 1'b0;
      if (($urandom % 32) == 0) prep_irq_dis = ~prep_irq_dis;
      cyc(w, d, 8'($urandom & $urandom & $urandom), 8'($urandom & $urandom),
          ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
          2'($urandom & $urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule